// File: doc/BRIEF.md
# Byte-Wide Nonvolatile Store Access Controller

This block gives a processor byte-at-a-time read and write access to a 1024-location nonvolatile data store. Software reaches the store only through six small registers: a control register, an unlock key port, a data register, and a 10-bit location address split into a low byte and a two-bit high part. There is also an interrupt flag register. A read is started by setting a start bit, and the byte appears in the data register on the next cycle. A write is accepted only after a two-byte key sequence. It then runs as a timed erase-then-program cycle, and software cannot shorten that cycle.

The store is modelled as a plain RAM. The cycle time is a parameter counted in clock cycles. The location is committed only when the timer expires. If a warm reset cuts a cycle short, the old byte stays in place and the error bit remains set to tell software. Two resets are provided. The power-up reset clears everything, including the error bit. The warm reset abandons operations and clears the control state, but it leaves the error bit readable.

Top module: `nvb_ctrl`

## Requirements
- R1: Register offsets are control=0, key=1, data=2, address-low=3, address-high=4, flag=5. All registers read 0 after power-up reset. The key register always reads 00h, even after it is written.
- R2: The location address is {address-high[1:0], address-low[7:0]}. Address-high keeps only bits 1:0 and reads 0 in bits 7:2. Locations that differ only in the high bits are distinct.
- R3: Writing control with bit0 (read start) set loads the addressed byte into the data register one cycle later. Bit0 reads 1 for that one cycle and then clears itself.
- R4: A read start has no effect if the same control write sets bit7 (program-memory select) or bit6 (configuration select). Bit0 stays 0 and the data register keeps its value.
- R5: A write starts only if all of the following hold. The previous two bus writes put 55h and then AAh into the key register. Then a control write sets bit1 (write start) and bit2 (write enable), with bits 7 and 6 clear. Any other write-start attempt leaves the store unchanged and sets bit3 (error).
- R6: A started write keeps bit1 at 1 for exactly WR_LAT cycles and then commits the byte to the location. Writing 0 to bit1 during that time does not clear it.
- R7: While a write is in progress, bus writes to the data and address registers are ignored.
- R8: When a write completes, flag bit0 and the irq output become 1. They stay 1 until software writes flag with bit0=1. Writing 0 to bit0 leaves the flag set.
- R9: A warm reset during a write leaves the location unchanged. It clears bit1, bit2 and the select bits, and leaves bit3 at 1. A power-up reset clears bit3.
- R10: Writing control with bit3=0 clears the error bit. Writing bit3=1 does not change it.
- R11: Any bus write other than the expected next key byte between 55h and AAh, or between AAh and the control write, cancels the unlock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-up reset, active low, asynchronous; clears all state |
| rst_n | input | 1 | Warm reset, active low; aborts a write and clears control state |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register offset for reads and writes |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for bus_addr, combinational |
| irq | output | 1 | Write-complete interrupt flag |

## Verification
The assertions assume that each reset is held low across at least one rising clock edge, so that the warm-reset abort is seen synchronously. They also assume that bus_addr and bus_wdata are steady around the clock edge whenever bus_we is high. The bench drives every bus signal on the falling edge and holds each reset for two full cycles, so these assumptions always hold. Random addresses and data stay within the 10-bit space. Random reads go only to locations the bench has written first, so no check depends on uninitialised array contents.

// File: rtl/nvb_pkg.sv
package nvb_pkg;
  typedef enum logic [2:0] {
    REG_CTRL = 3'd0,
    REG_KEY  = 3'd1,
    REG_DATA = 3'd2,
    REG_ALO  = 3'd3,
    REG_AHI  = 3'd4,
    REG_FLAG = 3'd5
  } nvb_reg_e;

  localparam int B_RGO  = 0;
  localparam int B_WGO  = 1;
  localparam int B_WEN  = 2;
  localparam int B_WERR = 3;
  localparam int B_CFG  = 6;
  localparam int B_PROG = 7;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  typedef enum logic [1:0] {
    UL_IDLE  = 2'd0,
    UL_HALF  = 2'd1,
    UL_ARMED = 2'd2
  } unlock_e;
endpackage

// File: rtl/nvb_unlock.sv
module nvb_unlock
  import nvb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stb,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       armed
);
  unlock_e st_q, st_nxt;

  always_comb begin
    st_nxt = st_q;
    if (wr_stb) begin
      if (wr_addr == REG_KEY && wr_data == KEY_FIRST)
        st_nxt = UL_HALF;
      else if (wr_addr == REG_KEY && wr_data == KEY_SECOND && st_q == UL_HALF)
        st_nxt = UL_ARMED;
      else
        st_nxt = UL_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= UL_IDLE;
    else        st_q <= st_nxt;
  end

  assign armed = (st_q == UL_ARMED);
endmodule

// File: rtl/nvb_wtimer.sv
module nvb_wtimer #(
  parameter int WR_LAT = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic start,
  input  logic abort,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(WR_LAT + 1);
  localparam logic [CW-1:0] LOAD = CW'(WR_LAT - 1);

  logic          busy_q, busy_nxt;
  logic [CW-1:0] cnt_q, cnt_nxt;

  always_comb begin
    busy_nxt = busy_q;
    cnt_nxt  = cnt_q;
    if (abort) begin
      busy_nxt = 1'b0;
      cnt_nxt  = '0;
    end else if (start && !busy_q) begin
      busy_nxt = 1'b1;
      cnt_nxt  = LOAD;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_nxt = 1'b0;
      else             cnt_nxt  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_nxt;
      cnt_q  <= cnt_nxt;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0) && !abort;
endmodule

// File: rtl/nvb_array.sv
module nvb_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/nvb_ctrl.sv
module nvb_ctrl
  import nvb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int WR_LAT = 16
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_n,
  input  logic       bus_we,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq
);
  localparam int HI_W = ADDR_W - 8;

  logic ctl_rst_n;
  assign ctl_rst_n = rst_n & por_n;

  // control-domain state
  logic            prog_sel, cfg_sel, wen, rgo, flag;
  logic [7:0]      data_q, addr_lo;
  logic [HI_W-1:0] addr_hi;
  logic            prog_sel_nxt, cfg_sel_nxt, wen_nxt, rgo_nxt, flag_nxt;
  logic [7:0]      data_nxt, addr_lo_nxt;
  logic [HI_W-1:0] addr_hi_nxt;
  // power-up-domain state
  logic            werr, werr_nxt;

  logic              armed, busy, done;
  logic [ADDR_W-1:0] loc;
  logic [7:0]        arr_rdata;

  logic wr_ctrl, wr_data, wr_alo, wr_ahi, wr_flag;
  logic tgt_data, rd_ok, wr_req, wr_ok, wr_bad;

  assign wr_ctrl = bus_we && (bus_addr == REG_CTRL);
  assign wr_data = bus_we && (bus_addr == REG_DATA);
  assign wr_alo  = bus_we && (bus_addr == REG_ALO);
  assign wr_ahi  = bus_we && (bus_addr == REG_AHI);
  assign wr_flag = bus_we && (bus_addr == REG_FLAG);

  assign tgt_data = !bus_wdata[B_PROG] && !bus_wdata[B_CFG];
  assign rd_ok    = wr_ctrl && bus_wdata[B_RGO] && tgt_data && !busy && !rgo;
  assign wr_req   = wr_ctrl && bus_wdata[B_WGO] && !busy;
  assign wr_ok    = wr_req && armed && bus_wdata[B_WEN] && tgt_data;
  assign wr_bad   = wr_req && !wr_ok;

  assign loc = {addr_hi, addr_lo};

  nvb_unlock u_unlock (
    .clk     (clk),
    .rst_n   (ctl_rst_n),
    .wr_stb  (bus_we),
    .wr_addr (bus_addr),
    .wr_data (bus_wdata),
    .armed   (armed)
  );

  nvb_wtimer #(.WR_LAT(WR_LAT)) u_timer (
    .clk   (clk),
    .por_n (por_n),
    .start (wr_ok),
    .abort (!rst_n),
    .busy  (busy),
    .done  (done)
  );

  nvb_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_array (
    .clk   (clk),
    .we    (done),
    .waddr (loc),
    .wdata (data_q),
    .raddr (loc),
    .rdata (arr_rdata)
  );

  always_comb begin
    prog_sel_nxt = prog_sel;
    cfg_sel_nxt  = cfg_sel;
    wen_nxt      = wen;
    rgo_nxt      = rgo;
    flag_nxt     = flag;
    data_nxt     = data_q;
    addr_lo_nxt  = addr_lo;
    addr_hi_nxt  = addr_hi;

    if (wr_ctrl) begin
      prog_sel_nxt = bus_wdata[B_PROG];
      cfg_sel_nxt  = bus_wdata[B_CFG];
      wen_nxt      = bus_wdata[B_WEN];
    end

    if (rgo)        rgo_nxt = 1'b0;
    else if (rd_ok) rgo_nxt = 1'b1;

    if (rgo)                  data_nxt = arr_rdata;
    else if (wr_data && !busy) data_nxt = bus_wdata;

    if (wr_alo && !busy) addr_lo_nxt = bus_wdata;
    if (wr_ahi && !busy) addr_hi_nxt = bus_wdata[HI_W-1:0];

    if (done)                         flag_nxt = 1'b1;
    else if (wr_flag && bus_wdata[0]) flag_nxt = 1'b0;
  end

  always_comb begin
    werr_nxt = werr;
    if (!rst_n)                            werr_nxt = werr | busy;
    else if (wr_bad)                       werr_nxt = 1'b1;
    else if (wr_ctrl && !bus_wdata[B_WERR]) werr_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge ctl_rst_n) begin
    if (!ctl_rst_n) begin
      prog_sel <= 1'b0;
      cfg_sel  <= 1'b0;
      wen      <= 1'b0;
      rgo      <= 1'b0;
      flag     <= 1'b0;
      data_q   <= '0;
      addr_lo  <= '0;
      addr_hi  <= '0;
    end else begin
      prog_sel <= prog_sel_nxt;
      cfg_sel  <= cfg_sel_nxt;
      wen      <= wen_nxt;
      rgo      <= rgo_nxt;
      flag     <= flag_nxt;
      data_q   <= data_nxt;
      addr_lo  <= addr_lo_nxt;
      addr_hi  <= addr_hi_nxt;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) werr <= 1'b0;
    else        werr <= werr_nxt;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      REG_CTRL: bus_rdata = {prog_sel, cfg_sel, 2'b00, werr, wen, busy, rgo};
      REG_DATA: bus_rdata = data_q;
      REG_ALO:  bus_rdata = addr_lo;
      REG_AHI:  bus_rdata = 8'(addr_hi);
      REG_FLAG: bus_rdata = {7'd0, flag};
      default:  bus_rdata = '0;
    endcase
  end

  assign irq = flag;
endmodule

// File: rtl/nvb_ctrl_chk.sv
module nvb_ctrl_chk
  import nvb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int WR_LAT = 16
) (
  input logic              clk,
  input logic              por_n,
  input logic              rst_n,
  input logic              bus_we,
  input logic [2:0]        bus_addr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              irq,
  input logic              busy,
  input logic              rgo,
  input logic [ADDR_W-1:0] loc
);
  localparam int LW = $clog2(WR_LAT + 2);

  logic [LW-1:0] busy_len;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      busy_len <= '0;
    else if (!rst_n) busy_len <= '0;
    else if (busy)   busy_len <= busy_len + 1'b1;
    else             busy_len <= '0;
  end

  assert_key_reads_zero_R1: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (bus_addr == REG_KEY) |-> (bus_rdata == 8'h00));

  assert_read_pulse_R3: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    rgo |=> !rgo);

  assert_write_cause_R5: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    $rose(busy) |-> $past(bus_we && bus_addr == REG_CTRL && bus_wdata[B_WGO]));

  assert_busy_bound_R6: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    busy_len <= LW'(WR_LAT));

  assert_busy_full_R6: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    $fell(busy) |-> (busy_len == LW'(WR_LAT)));

  assert_addr_frozen_R7: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (busy && $past(busy)) |-> $stable(loc));

  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    $rose(irq) |-> $fell(busy));
endmodule

bind nvb_ctrl nvb_ctrl_chk #(.ADDR_W(ADDR_W), .WR_LAT(WR_LAT)) u_chk (
  .clk       (clk),
  .por_n     (por_n),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .busy      (busy),
  .rgo       (rgo),
  .loc       (loc)
);

// File: tb/tb_nvb_ctrl.sv
`timescale 1ns/1ps
module tb_nvb_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 8;
  localparam int NRAND = 40;

  localparam logic [2:0] A_CTRL = 3'd0, A_KEY = 3'd1, A_DATA = 3'd2,
                         A_ALO = 3'd3, A_AHI = 3'd4, A_FLAG = 3'd5;

  logic       clk, por_n, rst_n, bus_we, irq;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;

  int checks, fails;
  logic [7:0] model [1024];
  logic [9:0] used_addr [NRAND];

  nvb_ctrl #(.ADDR_W(10), .WR_LAT(LAT)) dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] exp_ahi(input logic [7:0] w);
    return {6'd0, w[1:0]};
  endfunction

  function automatic logic [7:0] exp_byte(input logic [9:0] a);
    return model[a];
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic set_loc(input logic [9:0] a);
    bus_write(A_ALO, a[7:0]);
    bus_write(A_AHI, {6'd0, a[9:8]});
  endtask

  task automatic start_write(input logic [9:0] a, input logic [7:0] d);
    set_loc(a);
    bus_write(A_DATA, d);
    bus_write(A_KEY, 8'h55);
    bus_write(A_KEY, 8'hAA);
    bus_write(A_CTRL, 8'h0E);
  endtask

  task automatic full_write(input logic [9:0] a, input logic [7:0] d);
    start_write(a, d);
    repeat (LAT) @(negedge clk);
    model[a] = d;
    bus_write(A_FLAG, 8'h01);
  endtask

  task automatic do_read(input logic [9:0] a, output logic [7:0] v);
    set_loc(a);
    bus_write(A_CTRL, 8'h09);
    @(negedge clk);
    bus_read(A_DATA, v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [9:0] ra;
    logic [7:0] rd;
    int seed;
    checks = 0; fails = 0;
    seed = $urandom(32'd4242);
    bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    por_n = 1'b0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int r = 0; r < 6; r++) begin
      bus_read(3'(r), v);
      check("R1 reset value", v, 8'h00);
    end
    check("R8 irq after reset", {7'd0, irq}, 8'h00);

    // R1 key reads zero
    bus_write(A_KEY, 8'h55);
    bus_read(A_KEY, v); check("R1 key reads zero", v, 8'h00);
    bus_write(A_CTRL, 8'h08);

    // R2 high address masking
    bus_write(A_AHI, 8'hFF);
    bus_read(A_AHI, v); check("R2 addr-high mask", v, exp_ahi(8'hFF));

    // R6/R8 directed write with timing
    start_write(10'h3FF, 8'hA5);
    bus_read(A_CTRL, v); check("R6 busy at start", {7'd0, v[1]}, 8'h01);
    repeat (LAT - 1) @(negedge clk);
    bus_read(A_CTRL, v); check("R6 busy last cycle", {7'd0, v[1]}, 8'h01);
    check("R8 irq not yet", {7'd0, irq}, 8'h00);
    @(negedge clk);
    bus_read(A_CTRL, v); check("R6 busy cleared", {7'd0, v[1]}, 8'h00);
    check("R8 irq set", {7'd0, irq}, 8'h01);
    model[10'h3FF] = 8'hA5;
    repeat (5) @(negedge clk);
    bus_write(A_FLAG, 8'h00);
    bus_read(A_FLAG, v); check("R8 flag holds on write 0", v, 8'h01);
    bus_write(A_FLAG, 8'h01);
    bus_read(A_FLAG, v); check("R8 flag cleared", v, 8'h00);

    // R2 distinct high bits
    full_write(10'h0FF, 8'h5A);
    do_read(10'h3FF, v); check("R2 R3 read 3FF", v, exp_byte(10'h3FF));
    do_read(10'h0FF, v); check("R2 R3 read 0FF", v, exp_byte(10'h0FF));

    // R3 read pulse
    set_loc(10'h0FF);
    bus_write(A_CTRL, 8'h09);
    bus_read(A_CTRL, v); check("R3 read bit set", {7'd0, v[0]}, 8'h01);
    @(negedge clk);
    bus_read(A_CTRL, v); check("R3 read bit clears", {7'd0, v[0]}, 8'h00);

    // R4 read refused
    bus_write(A_DATA, 8'h11);
    bus_write(A_CTRL, 8'h89);
    bus_read(A_CTRL, v); check("R4 prog select read bit", {7'd0, v[0]}, 8'h00);
    @(negedge clk);
    bus_read(A_DATA, v); check("R4 prog select data kept", v, 8'h11);
    bus_write(A_CTRL, 8'h49);
    @(negedge clk);
    bus_read(A_DATA, v); check("R4 cfg select data kept", v, 8'h11);
    bus_write(A_CTRL, 8'h08);

    // R5 no unlock
    set_loc(10'h0FF);
    bus_write(A_DATA, 8'h77);
    bus_write(A_CTRL, 8'h06);
    bus_read(A_CTRL, v); check("R5 no unlock error", v, 8'h0C);
    repeat (LAT + 1) @(negedge clk);
    // R10 clear error
    bus_write(A_CTRL, 8'h04);
    bus_read(A_CTRL, v); check("R10 error cleared", v, 8'h04);
    bus_write(A_CTRL, 8'h0C);
    bus_read(A_CTRL, v); check("R10 writing 1 keeps 0", {7'd0, v[3]}, 8'h00);
    // R11 broken sequence
    bus_write(A_KEY, 8'h55);
    bus_write(A_DATA, 8'h77);
    bus_write(A_KEY, 8'hAA);
    bus_write(A_CTRL, 8'h06);
    bus_read(A_CTRL, v); check("R11 broken unlock", v, 8'h0C);
    bus_write(A_CTRL, 8'h04);
    // R5 missing enable
    bus_write(A_KEY, 8'h55);
    bus_write(A_KEY, 8'hAA);
    bus_write(A_CTRL, 8'h02);
    bus_read(A_CTRL, v); check("R5 no enable", v, 8'h08);
    // R5 program target
    bus_write(A_KEY, 8'h55);
    bus_write(A_KEY, 8'hAA);
    bus_write(A_CTRL, 8'h8E);
    bus_read(A_CTRL, v); check("R5 program target", v, 8'h8C);
    bus_write(A_CTRL, 8'h08);
    repeat (LAT + 1) @(negedge clk);
    check("R5 no completion irq", {7'd0, irq}, 8'h00);
    do_read(10'h0FF, v); check("R5 location unchanged", v, exp_byte(10'h0FF));

    // R7 ignored during busy, R6 not clearable
    full_write(10'h010, 8'h3C);
    start_write(10'h010, 8'hC3);
    bus_write(A_DATA, 8'hFF);
    bus_write(A_ALO, 8'h20);
    bus_write(A_CTRL, 8'h0C);
    bus_read(A_CTRL, v); check("R6 busy not cleared by software", {7'd0, v[1]}, 8'h01);
    repeat (LAT) @(negedge clk);
    model[10'h010] = 8'hC3;
    bus_read(A_DATA, v); check("R7 data ignored", v, 8'hC3);
    bus_read(A_ALO, v); check("R7 address ignored", v, 8'h10);
    bus_write(A_FLAG, 8'h01);
    do_read(10'h010, v); check("R7 committed byte", v, exp_byte(10'h010));

    // random writes then reads (R3 R6)
    for (int i = 0; i < NRAND; i++) begin
      used_addr[i] = 10'($urandom);
      full_write(used_addr[i], 8'($urandom));
    end
    for (int i = 0; i < NRAND; i++) begin
      ra = used_addr[$urandom % NRAND];
      do_read(ra, rd);
      check("R3 R6 random readback", rd, exp_byte(ra));
    end

    // R9 warm reset mid-write
    start_write(10'h010, 8'h77);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    bus_read(A_CTRL, v); check("R9 abort status", v, 8'h08);
    repeat (LAT) @(negedge clk);
    check("R9 no irq after abort", {7'd0, irq}, 8'h00);
    do_read(10'h010, v); check("R9 location unchanged", v, exp_byte(10'h010));
    bus_write(A_CTRL, 8'h08);
    por_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    bus_read(A_CTRL, v); check("R9 power-up clears error", v, 8'h00);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule